// File: doc/BRIEF.md
# Multithreaded Round-Robin Fetch Selector

This block sits at the front of a simultaneous multithreaded core. In each cycle it picks the one hardware thread that fetches, cuts that thread's fetched block down to a fetch group, and advances that thread's program counter. Each thread context has its own program counter register inside the block. The threads are independent of one another, so no ordering between them is enforced beyond the arbitration.

Every cycle, each thread presents a ready flag, a per-slot valid marking and a per-slot predicted-taken marking for its fetched block, and a predicted target. The block grants the first ready thread in round-robin order. The group starts at slot 0 and runs through the contiguous valid slots. It stops after the first slot predicted taken, which is itself included, or at the fetch width. The grant and the group are registered, so they appear one cycle after the inputs that produced them and stay valid for one cycle. A per-thread redirect loads a new program counter and takes priority over the update from fetch.

Top module: `mt_fetch_sel`

## Requirements
- R1: In each cycle at most one thread is granted, and only a thread whose ready flag was high in the cycle the group was formed. The grant appears on `grp_valid`/`grp_tid` one clock later.
- R2: The arbiter searches from the thread just after the last granted one, wrapping from the highest thread index to thread 0. After reset the search starts at thread 0.
- R3: Threads that are not ready are skipped. When no thread is ready, `grp_valid` is 0 in the next cycle and the search start point does not move.
- R4: Bit i of `grp_mask` (bit 0 = oldest slot) is set when slots 0..i are all valid and no slot below i is predicted taken. A taken slot is included in the group, and later slots are dropped. `grp_count` is the number of set mask bits and is never more than the fetch width.
- R5: When the group contains a slot predicted taken, the granted thread's next program counter is its presented target.
- R6: Otherwise the granted thread's next program counter is its current value plus `grp_count`. Program counters count instructions.
- R7: A redirect on a thread loads its redirect value as that thread's next program counter. This applies whether or not the thread is granted in that cycle, and overrides R5 and R6.
- R8: `grp_pc` is the program counter the granted thread held when its group was formed.
- R9: While reset is low, `grp_valid` is 0. Reset sets every thread's program counter to `RESET_PC` (default 0) and the search start to thread 0.
- R10: Each grant is reported for exactly one cycle. `grp_valid` falls in the cycle after a cycle with no ready thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | N_THR | Per-thread ready flag |
| thr_slot_valid | input | N_THR*FW | Per-thread slot valid, thread t at bits [t*FW +: FW] |
| thr_slot_taken | input | N_THR*FW | Per-thread slot predicted taken, same layout |
| thr_target | input | N_THR*PC_W | Per-thread predicted target |
| thr_redirect | input | N_THR | Per-thread redirect strobe |
| thr_redirect_pc | input | N_THR*PC_W | Per-thread redirect value |
| grp_valid | output | 1 | A fetch group is reported this cycle |
| grp_tid | output | TW | Granted thread index |
| grp_mask | output | FW | Slots belonging to the group |
| grp_count | output | CW | Number of instructions in the group |
| grp_pc | output | PC_W | Program counter of the group's first slot |

## Verification
Two functions can update the same program counter in one cycle: the fetch update (taken target or sequential advance) and a redirect. The bench raises a redirect on the thread that is being granted, in a cycle whose group ends on a taken branch. The next `grp_pc` reported for that thread must equal the redirect value and not the target. A redirect on a thread that is not granted is also applied, and the bench checks it at that thread's next grant.

// File: rtl/fetch_sel_pkg.sv
// Package: shared defaults and the group-end classification used by the
// fetch selector. Assumes nothing beyond plain synthesizable types.
package fetch_sel_pkg;
    localparam int DEF_THREADS = 4;
    localparam int DEF_WIDTH   = 4;
    localparam int DEF_PC_W    = 32;

    // Why a fetch group ended.
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_TAKEN = 2'd1,
        END_SEQ   = 2'd2
    } grp_end_e;
endpackage

// File: rtl/rr_thread_arb.sv
// Round-robin thread arbiter. Grants the first requesting thread found from
// the start pointer upward, wrapping. The pointer moves to the thread after
// the grant and holds when nothing requests.
// Assumes: N_THR >= 1; synchronous active-low reset.
module rr_thread_arb #(
    parameter int N_THR = 4,
    localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_THR-1:0] req,
    output logic             gnt_any,
    output logic [TW-1:0]    gnt_id
);
    logic [TW-1:0] ptr;

    // Search the requests in rotated order from ptr.
    always_comb begin
        int idx;
        gnt_any = 1'b0;
        gnt_id  = '0;
        for (int k = 0; k < N_THR; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N_THR) idx = idx - N_THR;
            if (!gnt_any && req[idx]) begin
                gnt_any = 1'b1;
                gnt_id  = TW'(idx);
            end
        end
    end

    // Advance the pointer past the granted thread.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (gnt_any)
            ptr <= (int'(gnt_id) == N_THR - 1) ? '0 : gnt_id + 1'b1;
    end

    // R3: idle cycles leave the search start where it was.
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |=> $stable(ptr));

    // R1: a grant always points at a requesting thread.
    a_r1_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_id]);
endmodule

// File: rtl/fetch_group_cut.sv
// Fetch group truncation. Keeps the contiguous valid slots from slot 0. It
// stops after the first slot predicted taken, which is kept.
// Assumes: slot 0 is the oldest slot of the block.
module fetch_group_cut
    import fetch_sel_pkg::*;
#(
    parameter int FW = 4,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic [FW-1:0] slot_valid,
    input  logic [FW-1:0] slot_taken,
    output logic [FW-1:0] keep,
    output logic [CW-1:0] count,
    output grp_end_e      end_kind
);
    // Prefix chain: each slot is kept only if every earlier one was kept
    // and was not predicted taken.
    for (genvar i = 0; i < FW; i++) begin : g_keep
        if (i == 0) begin : g_first
            assign keep[i] = slot_valid[i];
        end else begin : g_rest
            assign keep[i] = keep[i-1] & slot_valid[i] & ~slot_taken[i-1];
        end
    end

    // Count the kept slots and classify how the group ended.
    always_comb begin
        count = '0;
        for (int i = 0; i < FW; i++)
            count = count + CW'(keep[i]);
        if (|(keep & slot_taken))
            end_kind = END_TAKEN;
        else if (|keep)
            end_kind = END_SEQ;
        else
            end_kind = END_NONE;
    end
endmodule

// File: rtl/thread_pc_bank.sv
// Per-thread program counter registers. A redirect takes priority over the
// fetch update. Only the thread named by the update index is advanced.
// Assumes: upd_tid < N_THR whenever upd_en is high.
module thread_pc_bank #(
    parameter int N_THR = 4,
    parameter int PC_W = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_en,
    input  logic [TW-1:0]         upd_tid,
    input  logic [PC_W-1:0]       upd_pc,
    input  logic [N_THR-1:0]      redir,
    input  logic [N_THR*PC_W-1:0] redir_pc,
    output logic [N_THR*PC_W-1:0] pc_flat
);
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        logic [PC_W-1:0] pc_q;

        // Hold, redirect or advance this thread's program counter.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pc_q <= RESET_PC;
            else if (redir[t])
                pc_q <= redir_pc[t*PC_W +: PC_W];
            else if (upd_en && int'(upd_tid) == t)
                pc_q <= upd_pc;
        end

        assign pc_flat[t*PC_W +: PC_W] = pc_q;

        // R7: a redirect is always what the thread holds next.
        a_r7_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
            redir[t] |=> pc_q == $past(redir_pc[t*PC_W +: PC_W]));
    end
endmodule

// File: rtl/mt_fetch_sel.sv
// Multithreaded fetch selector top. Grants one ready thread per cycle in
// round-robin order, truncates its block into a fetch group and updates its
// program counter. The group is reported from registers one cycle later.
// Assumes: per-thread inputs are flattened, thread t at [t*W +: W].
module mt_fetch_sel
    import fetch_sel_pkg::*;
#(
    parameter int N_THR = DEF_THREADS,
    parameter int FW = DEF_WIDTH,
    parameter int PC_W = DEF_PC_W,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_THR-1:0]      thr_ready,
    input  logic [N_THR*FW-1:0]   thr_slot_valid,
    input  logic [N_THR*FW-1:0]   thr_slot_taken,
    input  logic [N_THR*PC_W-1:0] thr_target,
    input  logic [N_THR-1:0]      thr_redirect,
    input  logic [N_THR*PC_W-1:0] thr_redirect_pc,
    output logic                  grp_valid,
    output logic [TW-1:0]         grp_tid,
    output logic [FW-1:0]         grp_mask,
    output logic [CW-1:0]         grp_count,
    output logic [PC_W-1:0]       grp_pc
);
    logic                  gnt_any;
    logic [TW-1:0]         gnt_id;
    logic [FW-1:0]         keep;
    logic [CW-1:0]         count;
    grp_end_e              end_kind;
    logic [N_THR*PC_W-1:0] pc_flat;
    logic [PC_W-1:0]       cur_pc;
    logic [PC_W-1:0]       next_pc;

    rr_thread_arb #(.N_THR(N_THR)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (thr_ready),
        .gnt_any (gnt_any),
        .gnt_id  (gnt_id)
    );

    fetch_group_cut #(.FW(FW)) u_cut (
        .slot_valid (thr_slot_valid[gnt_id*FW +: FW]),
        .slot_taken (thr_slot_taken[gnt_id*FW +: FW]),
        .keep       (keep),
        .count      (count),
        .end_kind   (end_kind)
    );

    // Choose the granted thread's next PC: taken target or sequential.
    always_comb begin
        cur_pc  = pc_flat[gnt_id*PC_W +: PC_W];
        next_pc = (end_kind == END_TAKEN) ? thr_target[gnt_id*PC_W +: PC_W]
                                          : cur_pc + PC_W'(count);
    end

    thread_pc_bank #(.N_THR(N_THR), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_pcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (gnt_any),
        .upd_tid  (gnt_id),
        .upd_pc   (next_pc),
        .redir    (thr_redirect),
        .redir_pc (thr_redirect_pc),
        .pc_flat  (pc_flat)
    );

    // Register this cycle's group for one cycle of output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_valid <= 1'b0;
            grp_tid   <= '0;
            grp_mask  <= '0;
            grp_count <= '0;
            grp_pc    <= '0;
        end else begin
            grp_valid <= gnt_any;
            grp_tid   <= gnt_id;
            grp_mask  <= gnt_any ? keep : '0;
            grp_count <= gnt_any ? count : '0;
            grp_pc    <= cur_pc;
        end
    end

    // R3 / R10: no ready thread means no group next cycle.
    a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|thr_ready) |=> !grp_valid);

    // R1: the reported thread was ready when its group was formed.
    a_r1_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> |($past(thr_ready) & (N_THR'(1) << grp_tid)));

    // R4: the count matches the mask and stays within the width.
    a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
        grp_count == CW'($countones(grp_mask)) && int'(grp_count) <= FW);

    // R4: the mask is a prefix starting at slot 0.
    a_r4_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_mask & (grp_mask + FW'(1))) == '0);
endmodule

// File: tb/sim_mt_fetch_sel.sv
// Scoreboard bench: a driver task predicts each cycle's group and queues it;
// a monitor pops and compares after every clock edge.
module sim_mt_fetch_sel;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int FW = 4;
    localparam int PW = 32;
    localparam int TW = 2;
    localparam int CW = 3;

    typedef struct {
        bit          v;
        int          tid;
        logic [FW-1:0] mask;
        int          cnt;
        logic [PW-1:0] pc;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]  rdy = '0, redir = '0;
    logic [FW-1:0] vld [N];
    logic [FW-1:0] tkn [N];
    logic [PW-1:0] tgt [N];
    logic [PW-1:0] rpc [N];
    logic [N*FW-1:0] vld_f, tkn_f;
    logic [N*PW-1:0] tgt_f, rpc_f;
    logic          grp_valid;
    logic [TW-1:0] grp_tid;
    logic [FW-1:0] grp_mask;
    logic [CW-1:0] grp_count;
    logic [PW-1:0] grp_pc;

    int total = 0, bad = 0;
    exp_t q[$];
    int ptr_m = 0;
    logic [PW-1:0] pc_m [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int t = 0; t < N; t++) begin
            vld_f[t*FW +: FW] = vld[t];
            tkn_f[t*FW +: FW] = tkn[t];
            tgt_f[t*PW +: PW] = tgt[t];
            rpc_f[t*PW +: PW] = rpc[t];
        end
    end

    mt_fetch_sel #(.N_THR(N), .FW(FW), .PC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_ready(rdy),
        .thr_slot_valid(vld_f), .thr_slot_taken(tkn_f), .thr_target(tgt_f),
        .thr_redirect(redir), .thr_redirect_pc(rpc_f),
        .grp_valid(grp_valid), .grp_tid(grp_tid), .grp_mask(grp_mask),
        .grp_count(grp_count), .grp_pc(grp_pc));

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: predict the group from the present inputs, queue it, then
    // let one clock pass.
    task automatic run(input string tag);
        exp_t e;
        int g = -1;
        logic [PW-1:0] nxt;
        bit hit = 0;
        e.v = 0; e.tid = 0; e.mask = '0; e.cnt = 0; e.pc = '0; e.tag = tag;
        for (int k = 0; k < N; k++)
            if (g < 0 && rdy[(ptr_m + k) % N]) g = (ptr_m + k) % N;
        if (g >= 0) begin
            bit stop = 0;
            e.v = 1; e.tid = g; e.pc = pc_m[g];
            for (int i = 0; i < FW; i++) begin
                if (!stop && vld[g][i]) begin
                    e.mask[i] = 1'b1; e.cnt++;
                    if (tkn[g][i]) begin stop = 1; hit = 1; end
                end else stop = 1;
            end
            nxt = hit ? tgt[g] : pc_m[g] + PW'(e.cnt);
            ptr_m = (g + 1) % N;
        end
        for (int t = 0; t < N; t++) begin
            if (redir[t]) pc_m[t] = rpc[t];
            else if (t == g) pc_m[t] = nxt;
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare the registered group after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(grp_valid == e.v, e.tag, "valid", grp_valid, e.v);
            if (e.v && grp_valid) begin
                chk(int'(grp_tid) == e.tid, e.tag, "tid", grp_tid, e.tid);
                chk(grp_mask == e.mask, e.tag, "mask", grp_mask, e.mask);
                chk(int'(grp_count) == e.cnt, e.tag, "count", grp_count, e.cnt);
                chk(grp_pc == e.pc, e.tag, "pc", grp_pc, e.pc);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic set_all(input logic [FW-1:0] v, input logic [FW-1:0] tk);
        for (int t = 0; t < N; t++) begin vld[t] = v; tkn[t] = tk; end
    endtask

    initial begin
        for (int t = 0; t < N; t++) begin
            vld[t] = '0; tkn[t] = '0; tgt[t] = PW'(32'h1000 * (t + 1)); rpc[t] = '0;
            pc_m[t] = '0;
        end
        rdy = 4'b1111;
        repeat (3) @(negedge clk);
        // R9: held in reset with threads ready, no group comes out.
        chk(grp_valid == 1'b0, "R9", "valid in reset", grp_valid, 0);
        rst_n = 1'b1;

        // R2 / R6 / R8 / R9: full blocks, grants rotate 0,1,2,3,0,1 from PC 0.
        set_all(4'b1111, 4'b0000);
        repeat (6) run("R2_R6_R9");

        // R4 / R5: taken at slot 1 cuts the group to two slots, PC jumps.
        rdy = 4'b0100;
        tkn[2] = 4'b0010;
        run("R4_R5_taken_mid");
        tkn[2] = 4'b0000;
        run("R5_target_pc");
        // R4: taken on slot 0 gives a single instruction.
        tkn[2] = 4'b0001;
        run("R4_taken_first");
        // R4: taken mark on an invalid slot is ignored; a hole cuts the group.
        tkn[2] = 4'b1000; vld[2] = 4'b0111;
        run("R4_taken_invalid");
        vld[2] = 4'b1011; tkn[2] = 4'b0000;
        run("R4_hole");
        vld[2] = 4'b0000;
        run("R4_empty_block");

        // R3 / R10: nothing ready, no group and the pointer holds.
        rdy = 4'b0000;
        run("R3_R10_idle");
        run("R3_R10_idle");
        // R2 / R3: after thread 2, thread 3 is next; thread 0 skipped later.
        set_all(4'b1111, 4'b0000);
        rdy = 4'b1111;
        run("R2_after_idle");
        rdy = 4'b1110;
        run("R3_skip");
        run("R3_skip");

        // R7: redirect on the granted thread in a taken cycle wins.
        rdy = 4'b1111;
        tkn[3] = 4'b0100; rpc[3] = 32'h0000_ABC0;
        redir = 4'b1000;
        // Next grant is thread 3 (pointer sits after thread 2).
        run("R7_granted_redirect");
        redir = 4'b0000; tkn[3] = 4'b0000;
        // R7: redirect a thread that is not granted this cycle.
        rpc[1] = 32'h0000_5550; redir = 4'b0010;
        run("R7_idle_redirect");
        redir = 4'b0000;
        repeat (4) run("R7_R8_follow");

        // R10: a single ready cycle reports for exactly one cycle.
        rdy = 4'b0001;
        run("R10_pulse");
        rdy = 4'b0000;
        run("R10_drop");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule